// File: doc/BRIEF.md
# USB full-speed IN transaction engine

This block is the device-side controller for IN transactions on a full-speed USB link. It watches packets that the receiver has already decoded: PID, address, endpoint number, and start, end and valid strobes. When an IN token arrives for this device on an enabled endpoint, it picks one of three answers. It can send a data packet, answer NAK, or answer STALL. During a data phase it steps a byte address into an external packet buffer on each transmit data-get pulse. After the packet is sent it waits for the host handshake. That wait is guarded by a timeout that starts when the transmitter reports packet end.

Each endpoint has a data toggle. A toggle flips on a good ACK, is set by a SETUP token, can be loaded by a write strobe, and is cleared by link reset. Isochronous endpoints send data with no handshake phase. An IN token that arrives while the block waits for a handshake is accepted as a retry of the transaction. A rollback pulse marks every data transaction that ended without an ACK, so the buffer side can rewind. A separate pulse reports a NAK seen in the handshake slot. All outputs are registered.

Top module: `usb_in_xact_engine`

## Requirements
- R1: A token is accepted only if all four of these hold in the same cycle: `rx_pkt_end`, `rx_pkt_valid`, a token-class PID (`rx_pid[1:0]==2'b01`), and `rx_addr==dev_addr`. Only PID 4'b1001 starts an IN transaction. A token that fails any condition, or that carries any other token PID, produces no `tx_start`.
- R2: The endpoint index is `rx_endp` when `rx_endp < NUM_EP`, and 0 otherwise. An IN token starts a transaction only when the endpoint is implemented and its `ep_enable` bit is 1.
- R3: One cycle after the accepting edge, `tx_start` pulses for one cycle and `tx_pid` carries the answer. The answer is chosen in priority order:
  - isochronous: data;
  - else stalled: STALL (4'b1110);
  - else `ep_has_data` (sampled with the token) set: data;
  - else NAK (4'b1010).
  After STALL or NAK the block is idle.
- R4: A data answer uses DATA1 (4'b1011) when the endpoint's toggle is 1, and DATA0 (4'b0011) when it is 0.
- R5: `buf_addr` is 0 after reset, in idle and when a transaction starts. It increments by one on each `tx_data_get` cycle while data is being sent.
- R6: Data sending stops on the first of two events: `ep_data_done[ep]` is set (or nothing was flagged at token time), or a get pulse arrives while `buf_addr` is all ones. After either event, further get pulses leave `buf_addr` unchanged.
- R7: An isochronous endpoint returns to idle as soon as its data ends. It never times out, never rolls back and never changes its toggle.
- R8: A non-isochronous data phase starts the handshake wait only once `tx_pkt_end` is seen, whether that is at data end or later. If no `rx_pkt_start` arrives, `rollback` pulses exactly ACK_TIMEOUT+1 cycles after the wait begins. An `rx_pkt_start` in the cycle where the count reaches zero still wins.
- R9: In the handshake slot, the outcome depends on the packet that ends there:
  - a valid ACK (PID 4'b0010) flips the endpoint toggle and raises no pulse;
  - a valid NAK (PID 4'b1010) pulses `nak_evt`;
  - any other packet end pulses `rollback`.
- R10: An IN token in the handshake slot pulses `rollback` and restarts the transaction, replying again with the same data PID, when the endpoint is active. When the endpoint is inactive, the block goes to idle without replying.
- R11: `link_active` low or `link_reset` high forces the engine idle, which cancels any pending timeout. `link_reset` also clears all toggles.
- R12: Toggles reset to 0. An accepted SETUP token (4'b1101) on an active endpoint sets that endpoint's toggle to 1. `toggle_we` loads all toggles from `toggle_wdata` and takes precedence over flips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (48 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| link_reset | input | 1 | Bus reset seen on the link |
| link_active | input | 1 | Link is up and not suspended |
| dev_addr | input | 7 | Configured device address |
| rx_pkt_start | input | 1 | Receiver saw a packet begin |
| rx_pkt_end | input | 1 | Receiver packet end strobe |
| rx_pkt_valid | input | 1 | Ending packet passed its checks |
| rx_pid | input | 4 | Received PID |
| rx_addr | input | 7 | Received token address |
| rx_endp | input | 4 | Received token endpoint |
| tx_pkt_end | input | 1 | Transmitter finished its packet |
| tx_data_get | input | 1 | Transmitter consumed one byte |
| ep_enable | input | NUM_EP | IN endpoint enable bits |
| ep_iso | input | NUM_EP | Endpoint is isochronous |
| ep_stall | input | NUM_EP | Endpoint is stalled |
| ep_has_data | input | NUM_EP | Endpoint has a packet ready |
| ep_data_done | input | NUM_EP | Endpoint's packet is exhausted |
| toggle_we | input | 1 | Load all toggles |
| toggle_wdata | input | NUM_EP | Toggle values to load |
| tx_start | output | 1 | One-cycle request to transmit |
| tx_pid | output | 4 | PID to transmit |
| cur_ep | output | $clog2(NUM_EP) | Endpoint of the current transaction |
| buf_addr | output | BUF_AW | Byte address into the packet buffer |
| ep_toggle | output | NUM_EP | Per-endpoint data toggle |
| rollback | output | 1 | Transaction ended without ACK |
| nak_evt | output | 1 | NAK received in the handshake slot |

## Verification
The bench sweeps every endpoint number with data flagged and unflagged. It compares each reply with the priority order computed from its own endpoint table, so a design that let STALL beat isochronous, or answered unimplemented endpoint numbers, would show up in the sweep. Timeout checks sample `rollback` one cycle early and at the exact cycle. It also drives a receive start in the cycle where the count reaches zero. An off-by-one counter, or an expiry that overrides the start, fails these checks. Other checks drive the data-end edge, where an all-ones address that wraps without ending would keep stepping. They also cover a transmit end at data end, which a design that waits for a second one would never time out. The handshake tests send a corrupted ACK, a NAK, and a retry token into the handshake slot, and check that only a clean ACK moves the toggle.

// File: rtl/usb_in_pkg.sv
package usb_in_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_GOT_IN    = 3'd1,
    ST_SEND      = 3'd2,
    ST_TX_END    = 3'd3,
    ST_ACK_START = 3'd4,
    ST_ACK_WAIT  = 3'd5
  } xact_st_t;

  localparam logic [3:0] PID_IN    = 4'b1001;
  localparam logic [3:0] PID_SETUP = 4'b1101;
  localparam logic [3:0] PID_DATA0 = 4'b0011;
  localparam logic [3:0] PID_DATA1 = 4'b1011;
  localparam logic [3:0] PID_ACK   = 4'b0010;
  localparam logic [3:0] PID_NAK   = 4'b1010;
  localparam logic [3:0] PID_STALL = 4'b1110;
  localparam logic [1:0] PID_CLASS_TOKEN = 2'b01;
endpackage

// File: rtl/usb_in_rx_decode.sv
module usb_in_rx_decode import usb_in_pkg::*; #(
  parameter int NUM_EP = 4,
  localparam int EP_W = $clog2(NUM_EP)
) (
  input  logic              rx_pkt_end,
  input  logic              rx_pkt_valid,
  input  logic [3:0]        rx_pid,
  input  logic [6:0]        rx_addr,
  input  logic [3:0]        rx_endp,
  input  logic [6:0]        dev_addr,
  input  logic [NUM_EP-1:0] ep_enable,
  output logic              in_tok,
  output logic              setup_tok,
  output logic              ack_rx,
  output logic              nak_rx,
  output logic [EP_W-1:0]   ep_idx_d,
  output logic              ep_active
);
  logic good_end, tok_ok, in_hw;

  assign good_end  = rx_pkt_end & rx_pkt_valid;
  assign tok_ok    = good_end & (rx_pid[1:0] == PID_CLASS_TOKEN) & (rx_addr == dev_addr);
  assign in_tok    = tok_ok & (rx_pid == PID_IN);
  assign setup_tok = tok_ok & (rx_pid == PID_SETUP);
  assign ack_rx    = good_end & (rx_pid == PID_ACK);
  assign nak_rx    = good_end & (rx_pid == PID_NAK);

  assign in_hw     = ({1'b0, rx_endp} < 5'(NUM_EP));
  assign ep_idx_d  = in_hw ? rx_endp[EP_W-1:0] : '0;
  assign ep_active = in_hw & ep_enable[ep_idx_d];
endmodule

// File: rtl/usb_in_ack_timer.sv
module usb_in_ack_timer #(
  parameter int ACK_TIMEOUT = 72,
  localparam int TO_W = $clog2(ACK_TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic expired
);
  logic [TO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= TO_W'(ACK_TIMEOUT);
    end else if (run && cnt != '0) begin
      cnt <= cnt - TO_W'(1);
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/usb_in_toggle_bank.sv
module usb_in_toggle_bank #(
  parameter int NUM_EP = 4,
  localparam int EP_W = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_reset,
  input  logic              flip_en,
  input  logic [EP_W-1:0]   flip_idx,
  input  logic              setup_en,
  input  logic [EP_W-1:0]   setup_idx,
  input  logic              we,
  input  logic [NUM_EP-1:0] wdata,
  output logic [NUM_EP-1:0] toggle
);
  always_ff @(posedge clk) begin
    if (rst || link_reset) begin
      toggle <= '0;
    end else if (we) begin
      toggle <= wdata;
    end else begin
      if (setup_en) toggle[setup_idx] <= 1'b1;
      if (flip_en)  toggle[flip_idx]  <= ~toggle[flip_idx];
    end
  end
endmodule

// File: rtl/usb_in_fsm.sv
module usb_in_fsm import usb_in_pkg::*; #(
  parameter int NUM_EP = 4,
  parameter int BUF_AW = 6,
  localparam int EP_W = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_reset,
  input  logic              link_active,
  input  logic              in_tok,
  input  logic              ack_rx,
  input  logic              nak_rx,
  input  logic              rx_pkt_start,
  input  logic              rx_pkt_end,
  input  logic              ep_active,
  input  logic [EP_W-1:0]   ep_idx_d,
  input  logic [NUM_EP-1:0] ep_iso,
  input  logic [NUM_EP-1:0] ep_stall,
  input  logic [NUM_EP-1:0] ep_has_data,
  input  logic [NUM_EP-1:0] ep_data_done,
  input  logic [NUM_EP-1:0] toggle,
  input  logic              tx_pkt_end,
  input  logic              tx_data_get,
  input  logic              expired,
  output logic              timer_load,
  output logic              timer_run,
  output logic              flip_en,
  output logic              tx_start,
  output logic [3:0]        tx_pid,
  output logic [EP_W-1:0]   cur_ep,
  output logic [BUF_AW-1:0] buf_addr,
  output logic              rollback,
  output logic              nak_evt,
  output logic [2:0]        st_o
);
  xact_st_t   st, st_n;
  logic       has_data_q, more, data_end;
  logic       go_n, rb_n, nk_n;
  logic [3:0] pid_n, data_pid;

  assign more     = has_data_q & ~ep_data_done[cur_ep];
  assign data_end = ~more | ((&buf_addr) & tx_data_get);
  assign data_pid = toggle[cur_ep] ? PID_DATA1 : PID_DATA0;

  always_comb begin
    st_n    = st;
    go_n    = 1'b0;
    pid_n   = PID_NAK;
    rb_n    = 1'b0;
    nk_n    = 1'b0;
    flip_en = 1'b0;
    unique case (st)
      ST_IDLE: if (in_tok && ep_active) st_n = ST_GOT_IN;
      ST_GOT_IN: begin
        go_n = 1'b1;
        if (ep_iso[cur_ep]) begin
          st_n  = ST_SEND;
          pid_n = data_pid;
        end else if (ep_stall[cur_ep]) begin
          st_n  = ST_IDLE;
          pid_n = PID_STALL;
        end else if (has_data_q) begin
          st_n  = ST_SEND;
          pid_n = data_pid;
        end else begin
          st_n  = ST_IDLE;
          pid_n = PID_NAK;
        end
      end
      ST_SEND: begin
        if (data_end) begin
          if (ep_iso[cur_ep])  st_n = ST_IDLE;
          else if (tx_pkt_end) st_n = ST_ACK_START;
          else                 st_n = ST_TX_END;
        end
      end
      ST_TX_END: if (tx_pkt_end) st_n = ST_ACK_START;
      ST_ACK_START: begin
        if (rx_pkt_start) begin
          st_n = ST_ACK_WAIT;
        end else if (expired) begin
          st_n = ST_IDLE;
          rb_n = 1'b1;
        end
      end
      ST_ACK_WAIT: begin
        if (ack_rx) begin
          st_n    = ST_IDLE;
          flip_en = 1'b1;
        end else if (rx_pkt_end) begin
          st_n = (in_tok && ep_active) ? ST_GOT_IN : ST_IDLE;
          rb_n = ~nak_rx;
          nk_n = nak_rx;
        end
      end
      default: st_n = ST_IDLE;
    endcase
    if (link_reset || !link_active) st_n = ST_IDLE;
  end

  assign timer_load = (st_n == ST_ACK_START) && (st != ST_ACK_START);
  assign timer_run  = (st == ST_ACK_START);
  assign st_o       = st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      has_data_q <= 1'b0;
      cur_ep     <= '0;
      buf_addr   <= '0;
      tx_start   <= 1'b0;
      tx_pid     <= PID_NAK;
      rollback   <= 1'b0;
      nak_evt    <= 1'b0;
    end else begin
      st       <= st_n;
      tx_start <= go_n;
      tx_pid   <= go_n ? pid_n : tx_pid;
      rollback <= rb_n;
      nak_evt  <= nk_n;
      if (st_n == ST_GOT_IN) begin
        cur_ep     <= ep_idx_d;
        has_data_q <= ep_has_data[ep_idx_d];
      end
      if (st == ST_IDLE || st == ST_GOT_IN) begin
        buf_addr <= '0;
      end else if (st == ST_SEND && tx_data_get) begin
        buf_addr <= buf_addr + BUF_AW'(1);
      end
    end
  end
endmodule

// File: rtl/usb_in_xact_engine.sv
module usb_in_xact_engine import usb_in_pkg::*; #(
  parameter int NUM_EP      = 4,
  parameter int BUF_AW      = 6,
  parameter int ACK_TIMEOUT = 72,
  localparam int EP_W = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_reset,
  input  logic              link_active,
  input  logic [6:0]        dev_addr,
  input  logic              rx_pkt_start,
  input  logic              rx_pkt_end,
  input  logic              rx_pkt_valid,
  input  logic [3:0]        rx_pid,
  input  logic [6:0]        rx_addr,
  input  logic [3:0]        rx_endp,
  input  logic              tx_pkt_end,
  input  logic              tx_data_get,
  input  logic [NUM_EP-1:0] ep_enable,
  input  logic [NUM_EP-1:0] ep_iso,
  input  logic [NUM_EP-1:0] ep_stall,
  input  logic [NUM_EP-1:0] ep_has_data,
  input  logic [NUM_EP-1:0] ep_data_done,
  input  logic              toggle_we,
  input  logic [NUM_EP-1:0] toggle_wdata,
  output logic              tx_start,
  output logic [3:0]        tx_pid,
  output logic [EP_W-1:0]   cur_ep,
  output logic [BUF_AW-1:0] buf_addr,
  output logic [NUM_EP-1:0] ep_toggle,
  output logic              rollback,
  output logic              nak_evt
);
  logic            in_tok, setup_tok, ack_rx, nak_rx, ep_active;
  logic [EP_W-1:0] ep_idx_d;
  logic            timer_load, timer_run, expired, flip_en;
  logic [2:0]      fsm_state;

  usb_in_rx_decode #(.NUM_EP(NUM_EP)) u_dec (
    .rx_pkt_end(rx_pkt_end), .rx_pkt_valid(rx_pkt_valid), .rx_pid(rx_pid),
    .rx_addr(rx_addr), .rx_endp(rx_endp), .dev_addr(dev_addr),
    .ep_enable(ep_enable), .in_tok(in_tok), .setup_tok(setup_tok),
    .ack_rx(ack_rx), .nak_rx(nak_rx), .ep_idx_d(ep_idx_d), .ep_active(ep_active)
  );

  usb_in_ack_timer #(.ACK_TIMEOUT(ACK_TIMEOUT)) u_tmr (
    .clk(clk), .rst(rst), .load(timer_load), .run(timer_run), .expired(expired)
  );

  usb_in_toggle_bank #(.NUM_EP(NUM_EP)) u_tog (
    .clk(clk), .rst(rst), .link_reset(link_reset),
    .flip_en(flip_en), .flip_idx(cur_ep),
    .setup_en(setup_tok & ep_active), .setup_idx(ep_idx_d),
    .we(toggle_we), .wdata(toggle_wdata), .toggle(ep_toggle)
  );

  usb_in_fsm #(.NUM_EP(NUM_EP), .BUF_AW(BUF_AW)) u_fsm (
    .clk(clk), .rst(rst), .link_reset(link_reset), .link_active(link_active),
    .in_tok(in_tok), .ack_rx(ack_rx), .nak_rx(nak_rx),
    .rx_pkt_start(rx_pkt_start), .rx_pkt_end(rx_pkt_end),
    .ep_active(ep_active), .ep_idx_d(ep_idx_d),
    .ep_iso(ep_iso), .ep_stall(ep_stall), .ep_has_data(ep_has_data),
    .ep_data_done(ep_data_done), .toggle(ep_toggle),
    .tx_pkt_end(tx_pkt_end), .tx_data_get(tx_data_get), .expired(expired),
    .timer_load(timer_load), .timer_run(timer_run), .flip_en(flip_en),
    .tx_start(tx_start), .tx_pid(tx_pid), .cur_ep(cur_ep), .buf_addr(buf_addr),
    .rollback(rollback), .nak_evt(nak_evt), .st_o(fsm_state)
  );
endmodule

// File: rtl/usb_in_xact_chk.sv
module usb_in_xact_chk #(
  parameter int NUM_EP = 4,
  parameter int BUF_AW = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        st,
  input logic              tx_start,
  input logic [3:0]        tx_pid,
  input logic              rollback,
  input logic              nak_evt,
  input logic [BUF_AW-1:0] buf_addr,
  input logic [NUM_EP-1:0] ep_toggle,
  input logic              toggle_we,
  input logic              link_reset,
  input logic              rx_pkt_end
);
  // R3
  state_legal_chk: assert property (@(posedge clk) disable iff (rst) st <= 3'd5);
  // R3
  reply_pid_chk: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> (tx_pid == 4'b0011 || tx_pid == 4'b1011 || tx_pid == 4'b1010 || tx_pid == 4'b1110));
  // R9
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst) !(rollback && nak_evt));
  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (buf_addr != $past(buf_addr)) |-> (buf_addr == $past(buf_addr) + BUF_AW'(1) || buf_addr == '0));
  // R11
  link_idle_chk: assert property (@(posedge clk) disable iff (rst) link_reset |=> st == 3'd0);
  // R12
  toggle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!toggle_we && !link_reset && !rx_pkt_end) |=> $stable(ep_toggle));
  // R8
  rollback_src_chk: assert property (@(posedge clk) disable iff (rst)
    rollback |-> ($past(st) == 3'd4 || $past(st) == 3'd5));
endmodule

bind usb_in_xact_engine usb_in_xact_chk #(.NUM_EP(NUM_EP), .BUF_AW(BUF_AW)) u_chk (
  .clk(clk), .rst(rst), .st(fsm_state), .tx_start(tx_start), .tx_pid(tx_pid),
  .rollback(rollback), .nak_evt(nak_evt), .buf_addr(buf_addr), .ep_toggle(ep_toggle),
  .toggle_we(toggle_we), .link_reset(link_reset), .rx_pkt_end(rx_pkt_end)
);

// File: tb/usb_in_xact_engine_test.sv
module usb_in_xact_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int NEP = 4;
  localparam int AW  = 3;
  localparam int T   = 8;
  localparam logic [6:0] DEV = 7'h2A;
  localparam logic [3:0] P_IN = 4'b1001, P_SOF = 4'b0101, P_SETUP = 4'b1101;
  localparam logic [3:0] P_D0 = 4'b0011, P_D1 = 4'b1011, P_ACK = 4'b0010;
  localparam logic [3:0] P_NAK = 4'b1010, P_STALL = 4'b1110;
  localparam logic [NEP-1:0] EN = 4'b0111, ISO = 4'b0010, STL = 4'b0110;

  logic clk = 0, rst = 1, link_reset = 0, link_active = 1;
  logic rx_pkt_start = 0, rx_pkt_end = 0, rx_pkt_valid = 0;
  logic [3:0] rx_pid = 0, rx_endp = 0;
  logic [6:0] rx_addr = 0;
  logic tx_pkt_end = 0, tx_data_get = 0, toggle_we = 0;
  logic [NEP-1:0] ep_has_data = 0, ep_data_done = 0, toggle_wdata = 0;
  logic tx_start, rollback, nak_evt;
  logic [3:0] tx_pid;
  logic [1:0] cur_ep;
  logic [AW-1:0] buf_addr;
  logic [NEP-1:0] ep_toggle;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_in_xact_engine #(.NUM_EP(NEP), .BUF_AW(AW), .ACK_TIMEOUT(T)) uut (
    .clk(clk), .rst(rst), .link_reset(link_reset), .link_active(link_active),
    .dev_addr(DEV), .rx_pkt_start(rx_pkt_start), .rx_pkt_end(rx_pkt_end),
    .rx_pkt_valid(rx_pkt_valid), .rx_pid(rx_pid), .rx_addr(rx_addr), .rx_endp(rx_endp),
    .tx_pkt_end(tx_pkt_end), .tx_data_get(tx_data_get), .ep_enable(EN), .ep_iso(ISO),
    .ep_stall(STL), .ep_has_data(ep_has_data), .ep_data_done(ep_data_done),
    .toggle_we(toggle_we), .toggle_wdata(toggle_wdata), .tx_start(tx_start),
    .tx_pid(tx_pid), .cur_ep(cur_ep), .buf_addr(buf_addr), .ep_toggle(ep_toggle),
    .rollback(rollback), .nak_evt(nak_evt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_pkt(input logic [3:0] pid, input logic [6:0] addr,
                          input logic [3:0] endp, input logic valid);
    rx_pid = pid; rx_addr = addr; rx_endp = endp; rx_pkt_valid = valid; rx_pkt_end = 1;
    step(1);
    rx_pkt_end = 0; rx_pkt_valid = 0;
  endtask

  task automatic do_in(input logic [3:0] pid, input logic [6:0] addr, input logic [3:0] endp,
                       input logic valid, output logic s, output logic [3:0] p);
    send_pkt(pid, addr, endp, valid);
    step(1);
    s = tx_start; p = tx_pid;
  endtask

  task automatic cleanup();
    ep_data_done = '1; step(1);
    tx_pkt_end = 1; step(1); tx_pkt_end = 0;
    step(T + 3);
    ep_data_done = '0;
  endtask

  task automatic pulse_start();
    rx_pkt_start = 1; step(1); rx_pkt_start = 0;
  endtask

  task automatic to_ack_wait(output logic s, output logic [3:0] p);
    do_in(P_IN, DEV, 0, 1, s, p);
    ep_data_done = 4'b0001; tx_pkt_end = 1; step(1);
    ep_data_done = 0; tx_pkt_end = 0;
    pulse_start();
  endtask

  task automatic watch_rb(input int n, output int seen);
    seen = 0;
    repeat (n) begin step(1); if (rollback) seen++; end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic s; logic [3:0] p; int seen, exp_pid; logic exp_s;
    step(3); rst = 0; step(1);
    chk("R3 reset tx_start", int'(tx_start), 0);
    chk("R5 reset buf_addr", int'(buf_addr), 0);
    chk("R12 reset toggles", int'(ep_toggle), 0);
    chk("R8 reset rollback", int'(rollback), 0);
    chk("R9 reset nak_evt", int'(nak_evt), 0);

    // R1 R2 R3 sweep over every endpoint number and data flag
    for (int e = 0; e < 16; e++) begin
      for (int h = 0; h < 2; h++) begin
        ep_has_data = h[0] ? '1 : '0;
        exp_s = 1; exp_pid = 0;
        if (e >= NEP || !EN[e]) exp_s = 0;
        else if (ISO[e]) exp_pid = P_D0;
        else if (STL[e]) exp_pid = P_STALL;
        else if (h == 1) exp_pid = P_D0;
        else exp_pid = P_NAK;
        do_in(P_IN, DEV, 4'(e), 1, s, p);
        chk($sformatf("R2 sweep start ep%0d h%0d", e, h), int'(s), int'(exp_s));
        if (exp_s) chk($sformatf("R3 sweep pid ep%0d h%0d", e, h), int'(p), exp_pid);
        cleanup();
      end
    end
    ep_has_data = 0;

    // R1 qualification failures (ep0 would NAK otherwise)
    do_in(P_IN, DEV ^ 7'h01, 0, 1, s, p);  chk("R1 wrong address", int'(s), 0);
    do_in(P_IN, DEV, 0, 0, s, p);          chk("R1 invalid packet", int'(s), 0);
    do_in(P_SOF, DEV, 0, 1, s, p);         chk("R1 other token PID", int'(s), 0);
    do_in(P_IN, DEV, 0, 1, s, p);          chk("R1 good token NAK", int'(p), int'(P_NAK));

    // R5 R6 address stepping and all-ones end
    ep_has_data = 4'b0001;
    do_in(P_IN, DEV, 0, 1, s, p);
    chk("R4 first data pid", int'(p), int'(P_D0));
    chk("R5 start addr", int'(buf_addr), 0);
    tx_data_get = 1;
    for (int i = 1; i <= 8; i++) begin
      step(1);
      chk($sformatf("R5 addr after get %0d", i), int'(buf_addr), i % 8);
    end
    step(1);
    chk("R6 get after all-ones end ignored", int'(buf_addr), 0);
    tx_data_get = 0;
    tx_pkt_end = 1; step(1); tx_pkt_end = 0;
    pulse_start();
    send_pkt(P_ACK, 0, 0, 1);
    chk("R9 ack flips toggle", int'(ep_toggle[0]), 1);
    chk("R9 ack no rollback", int'(rollback), 0);

    // R4 R6 R8: toggle used, done with tx end at once, exact timeout
    do_in(P_IN, DEV, 0, 1, s, p);
    chk("R4 data pid after ack", int'(p), int'(P_D1));
    chk("R5 addr reset on new xact", int'(buf_addr), 0);
    ep_data_done = 4'b0001; tx_pkt_end = 1; step(1);
    ep_data_done = 0; tx_pkt_end = 0;
    step(T);
    chk("R8 no rollback one cycle early", int'(rollback), 0);
    step(1);
    chk("R8 rollback at timeout", int'(rollback), 1);

    // R8 wait for tx end, then start wins at count zero
    do_in(P_IN, DEV, 0, 1, s, p);
    ep_data_done = 4'b0001; step(1); ep_data_done = 0;
    watch_rb(T + 3, seen);
    chk("R8 timer idle before tx end", seen, 0);
    tx_pkt_end = 1; step(1); tx_pkt_end = 0;
    step(T);
    pulse_start();
    chk("R8 start at zero count wins", int'(rollback), 0);
    send_pkt(P_NAK, 0, 0, 1);
    chk("R9 nak pulse", int'(nak_evt), 1);
    chk("R9 nak no rollback", int'(rollback), 0);
    chk("R9 nak keeps toggle", int'(ep_toggle[0]), 1);

    // R9 corrupted ACK
    to_ack_wait(s, p);
    send_pkt(P_ACK, 0, 0, 0);
    chk("R9 bad ack rollback", int'(rollback), 1);
    chk("R9 bad ack keeps toggle", int'(ep_toggle[0]), 1);

    // R10 retry on active and inactive endpoint
    to_ack_wait(s, p);
    send_pkt(P_IN, DEV, 0, 1);
    chk("R10 retry rollback", int'(rollback), 1);
    step(1);
    chk("R10 retry reply", int'(tx_start), 1);
    chk("R10 retry same pid", int'(tx_pid), int'(P_D1));
    cleanup();
    to_ack_wait(s, p);
    send_pkt(P_IN, DEV, 3, 1);
    chk("R10 inactive retry rollback", int'(rollback), 1);
    step(1);
    chk("R10 inactive retry no reply", int'(tx_start), 0);
    do_in(P_IN, DEV, 0, 1, s, p);
    chk("R10 idle after inactive retry", int'(s), 1);
    cleanup();

    // R7 isochronous: data then straight to idle
    ep_has_data = 4'b0010;
    do_in(P_IN, DEV, 1, 1, s, p);
    chk("R7 iso reply data", int'(p), int'(P_D0));
    tx_data_get = 1; step(2); tx_data_get = 0;
    chk("R5 iso addr", int'(buf_addr), 2);
    ep_data_done = 4'b0010; step(1); ep_data_done = 0;
    tx_pkt_end = 1; step(1); tx_pkt_end = 0;
    watch_rb(T + 3, seen);
    chk("R7 iso never rolls back", seen, 0);
    chk("R7 iso toggle unchanged", int'(ep_toggle[1]), 0);
    do_in(P_IN, DEV, 1, 1, s, p);
    chk("R7 iso idle again", int'(s), 1);
    cleanup();
    ep_has_data = 4'b0001;

    // R12 setup and write strobe
    send_pkt(P_SETUP, DEV, 2, 1);
    send_pkt(P_SETUP, DEV, 3, 1);
    chk("R12 setup sets active only", int'(ep_toggle), 5);
    toggle_we = 1; toggle_wdata = 4'b1010; step(1); toggle_we = 0;
    chk("R12 write strobe", int'(ep_toggle), 10);

    // R11 link inactive cancels timeout, link reset clears toggles
    do_in(P_IN, DEV, 0, 1, s, p);
    ep_data_done = 4'b0001; tx_pkt_end = 1; step(1);
    ep_data_done = 0; tx_pkt_end = 0;
    link_active = 0; step(1); link_active = 1;
    watch_rb(T + 3, seen);
    chk("R11 inactive cancels timeout", seen, 0);
    chk("R11 inactive keeps toggles", int'(ep_toggle), 10);
    do_in(P_IN, DEV, 0, 1, s, p);
    link_reset = 1; step(1); link_reset = 0;
    chk("R11 link reset clears toggles", int'(ep_toggle), 0);
    tx_data_get = 1; step(1); tx_data_get = 0;
    chk("R11 idle after link reset", int'(buf_addr), 0);
    do_in(P_IN, DEV, 0, 1, s, p);
    chk("R11 accepts after link reset", int'(s), 1);
    cleanup();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule